// File: doc/BRIEF.md
# DCT Output Post-Processing Stage

This block finishes the coefficients of an odd-length discrete cosine transform whose inner products come from a two-channel convolution array. On every accepted beat the array hands over two half-results `Y`, one per channel. The block adds the stored DC term `xa0` to twice each half-result. It then scales each sum by the fixed-point cosine constant that belongs to that channel's output index. The two finished coefficients leave in parallel, each tagged with its index `k`. The DC coefficient X(0) equals `xa0` itself and leaves on a separate port with no multiply.

A frame is `H = (N-1)/2` beats long. A beat with the tag bit set opens a frame. On that beat the tag also makes the block take the offset from the `in_xa0` port instead of the held register, and it captures that word for the rest of the frame. On beat `j` of a frame, lane 1 carries index `G^j mod N` and lane 2 carries the mirror index `N - G^j mod N`. Here `G` is a primitive root of the prime `N`, so a frame covers every index from 1 to N-1 exactly once.

A two-state controller (`S_WAIT`, `S_FRAME`) sequences the frame. There are four transitions:
- start: a tagged beat in `S_WAIT` goes to `S_FRAME`, or stays in `S_WAIT` when H = 1.
- advance: an untagged beat in `S_FRAME` that is not the last beat stays in `S_FRAME` and steps the beat count.
- finish: the last beat returns to `S_WAIT`.
- restart: a tagged beat in `S_FRAME` reopens the frame at beat 0.

Each lane is a two-register pipeline, so results appear two cycles after their beat.

Top module: `dctpp_top`

## Requirements
- R1: While reset is held, and on the first edges after it, `out_valid` and `dc_valid` are 0.
- R2: A tagged valid beat makes `dc_valid` 1 two cycles later, with `dc_x` equal to the `in_xa0` of that beat.
- R3: Two cycles after an accepted beat, each lane outputs `((off + 2*y) * C(k)) >>> (M-1)`. Here `C(k) = floor(cos(k*pi/(2N)) * 2^(M-1))` and `>>>` rounds toward minus infinity. The bench accepts a result within one LSB of this value.
- R4: On beat `j` of a frame (j counted from 0 at the tagged beat), `out_k1 = G^j mod N` and `out_k2 = N - out_k1`. Both are unsigned binary.
- R5: On a tagged beat the offset is that beat's `in_xa0`. On untagged beats the offset is the word captured at the tag, and `in_xa0` has no effect.
- R6: A frame ends after H accepted beats. An untagged valid beat that arrives outside a frame produces no output.
- R7: A tagged beat in the middle of a frame restarts it at beat 0 with the new `in_xa0`.
- R8: A cycle with `in_valid` low does not advance the beat count, and produces no output two cycles later.
- R9: `out_valid` is 1 only two cycles after an accepted beat, and it always covers both lanes together.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat present on the result inputs |
| in_tag | input | 1 | Frame start; selects the `in_xa0` port as the offset |
| in_xa0 | input | W | DC term of the frame (signed) |
| in_y1 | input | W | Channel 1 half-result (signed) |
| in_y2 | input | W | Channel 2 half-result (signed) |
| out_valid | output | 1 | Both lane results valid |
| out_k1 | output | clog2(N) | Index of lane 1 result |
| out_x1 | output | W+2 | Lane 1 coefficient (signed) |
| out_k2 | output | clog2(N) | Index of lane 2 result |
| out_x2 | output | W+2 | Lane 2 coefficient (signed) |
| dc_valid | output | 1 | X(0) valid |
| dc_x | output | W | X(0) (signed) |

## Verification
The bench builds the block with N = 7, G = 3, W = 8 and M = 8. An 8-bit half-result then takes only 256 values, so every channel input is swept completely against sixteen spread DC words, and every index 1..6 with its cosine constant is reached. The small width also puts the most negative and most positive sums within easy reach, where truncation toward minus infinity matters. Directed sequences then cover untagged beats outside a frame, restarts in mid-frame, idle gaps and junk on `in_xa0`.

// File: rtl/dctpp_pkg.sv
package dctpp_pkg;

    typedef enum logic [0:0] {S_WAIT, S_FRAME} pp_state_t;

    // G^j mod n: channel-1 output index on beat j of a frame
    function automatic int perm_of(int n, int g, int j);
        int r;
        r = 1;
        for (int i = 0; i < j; i++) r = (r * g) % n;
        return r;
    endfunction

    // floor(cos(k*pi/(2n)) * 2^(m-1)), positive for 0 < k < n
    function automatic int coef_of(int n, int m, int k);
        real a;
        a = 3.14159265358979 * k / (2.0 * n);
        return $rtoi($floor($cos(a) * (2.0 ** (m - 1))));
    endfunction

endpackage

// File: rtl/dctpp_ctrl.sv
module dctpp_ctrl
    import dctpp_pkg::*;
#(
    parameter int N  = 7,
    parameter int G  = 3,
    parameter int W  = 12,
    parameter int KW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_tag,
    input  logic signed [W-1:0] in_xa0,
    output logic                beat,
    output logic                first,
    output logic [KW-1:0]       k1,
    output logic [KW-1:0]       k2,
    output logic signed [W-1:0] off
);
    localparam int H  = (N - 1) / 2;
    localparam int CW = (H > 1) ? $clog2(H) : 1;
    localparam int PT = 2 ** CW;

    pp_state_t             state, nstate;
    logic [CW-1:0]         cnt, ncnt, jcur;
    logic signed [W-1:0]   held;
    logic [KW-1:0]         ptab [PT];

    for (genvar j = 0; j < PT; j++) begin : g_ptab
        if (j < H) begin : g_used
            assign ptab[j] = KW'(perm_of(N, G, j));
        end else begin : g_spare
            assign ptab[j] = KW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_WAIT;
            cnt   <= '0;
            held  <= '0;
        end else begin
            state <= nstate;
            cnt   <= ncnt;
            if (beat && in_tag) held <= in_xa0;
        end
    end

    always_comb begin
        beat   = 1'b0;
        jcur   = cnt;
        nstate = state;
        ncnt   = cnt;
        unique case (state)
            S_WAIT: begin
                if (in_valid && in_tag) begin
                    beat = 1'b1;
                    jcur = '0;
                end
            end
            S_FRAME: begin
                if (in_valid) begin
                    beat = 1'b1;
                    jcur = in_tag ? '0 : cnt;
                end
            end
            default: ;
        endcase
        if (beat) begin
            if (jcur == CW'(H - 1)) begin
                nstate = S_WAIT;
                ncnt   = '0;
            end else begin
                nstate = S_FRAME;
                ncnt   = jcur + 1'b1;
            end
        end
        first = beat && in_tag;
        off   = in_tag ? in_xa0 : held;
        k1    = ptab[jcur];
        k2    = KW'(N) - ptab[jcur];
    end

endmodule

// File: rtl/dctpp_lane.sv
module dctpp_lane
    import dctpp_pkg::*;
#(
    parameter int N  = 7,
    parameter int W  = 12,
    parameter int M  = 12,
    parameter int KW = $clog2(N)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  v_in,
    input  logic signed [W-1:0]   off,
    input  logic signed [W-1:0]   y,
    input  logic [KW-1:0]         k_in,
    output logic                  v_out,
    output logic [KW-1:0]         k_out,
    output logic signed [W+1:0]   x_out
);
    localparam int SW = W + 2;
    localparam int KT = 2 ** KW;

    logic signed [M-1:0]    ctab [KT];
    logic                   s1_v;
    logic [KW-1:0]          s1_k;
    logic signed [SW-1:0]   s1_sum;
    logic signed [SW+M-1:0] prod;

    for (genvar k = 0; k < KT; k++) begin : g_ctab
        if (k > 0 && k < N) begin : g_used
            assign ctab[k] = M'(coef_of(N, M, k));
        end else begin : g_spare
            assign ctab[k] = '0;
        end
    end

    assign prod = s1_sum * ctab[s1_k];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v   <= 1'b0;
            s1_k   <= '0;
            s1_sum <= '0;
            v_out  <= 1'b0;
            k_out  <= '0;
            x_out  <= '0;
        end else begin
            s1_v   <= v_in;
            s1_k   <= k_in;
            s1_sum <= SW'(off) + (SW'(y) <<< 1);
            v_out  <= s1_v;
            k_out  <= s1_k;
            x_out  <= prod[M-1 +: SW];
        end
    end

endmodule

// File: rtl/dctpp_top.sv
module dctpp_top
    import dctpp_pkg::*;
#(
    parameter int N  = 7,
    parameter int G  = 3,
    parameter int W  = 12,
    parameter int M  = 12,
    parameter int KW = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic                in_tag,
    input  logic signed [W-1:0] in_xa0,
    input  logic signed [W-1:0] in_y1,
    input  logic signed [W-1:0] in_y2,
    output logic                out_valid,
    output logic [KW-1:0]       out_k1,
    output logic signed [W+1:0] out_x1,
    output logic [KW-1:0]       out_k2,
    output logic signed [W+1:0] out_x2,
    output logic                dc_valid,
    output logic signed [W-1:0] dc_x
);
    logic                beat, first;
    logic [KW-1:0]       kk   [2];
    logic [KW-1:0]       ko   [2];
    logic signed [W-1:0] yy   [2];
    logic signed [W+1:0] xo   [2];
    logic                vo   [2];
    logic signed [W-1:0] off;
    logic                dc_v1;
    logic signed [W-1:0] dc_d1;

    dctpp_ctrl #(.N(N), .G(G), .W(W), .KW(KW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
        .in_xa0(in_xa0), .beat(beat), .first(first),
        .k1(kk[0]), .k2(kk[1]), .off(off)
    );

    assign yy[0] = in_y1;
    assign yy[1] = in_y2;

    for (genvar i = 0; i < 2; i++) begin : g_lane
        dctpp_lane #(.N(N), .W(W), .M(M), .KW(KW)) u_lane (
            .clk(clk), .rst_n(rst_n), .v_in(beat), .off(off), .y(yy[i]),
            .k_in(kk[i]), .v_out(vo[i]), .k_out(ko[i]), .x_out(xo[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dc_v1    <= 1'b0;
            dc_d1    <= '0;
            dc_valid <= 1'b0;
            dc_x     <= '0;
        end else begin
            dc_v1    <= first;
            dc_d1    <= in_xa0;
            dc_valid <= dc_v1;
            dc_x     <= dc_d1;
        end
    end

    assign out_valid = vo[0] & vo[1];
    assign out_k1    = ko[0];
    assign out_x1    = xo[0];
    assign out_k2    = ko[1];
    assign out_x2    = xo[1];

endmodule

// File: rtl/dctpp_checker.sv
module dctpp_checker #(
    parameter int N  = 7,
    parameter int W  = 12,
    parameter int KW = $clog2(N)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                in_tag,
    input logic signed [W-1:0] in_xa0,
    input logic                out_valid,
    input logic [KW-1:0]       out_k1,
    input logic [KW-1:0]       out_k2,
    input logic                dc_valid,
    input logic signed [W-1:0] dc_x
);
    logic [1:0] cyc;

    always_ff @(posedge clk) begin
        if (!rst_n) cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    a_r9_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cyc >= 2'd2) |-> $past(in_valid, 2));

    a_r2_dc_value: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_valid && cyc >= 2'd2) |-> ($past(in_tag, 2) && dc_x == $past(in_xa0, 2)));

    a_r2_dc_with_pair: assert property (@(posedge clk) disable iff (!rst_n)
        dc_valid |-> out_valid);

    a_r4_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_k1) + int'(out_k2) == N));

    a_r4_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_k1 != '0 && int'(out_k1) < N));

    a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc < 2'd2) |-> (!out_valid && !dc_valid));

endmodule

bind dctpp_top dctpp_checker #(.N(N), .W(W), .KW(KW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .in_xa0(in_xa0), .out_valid(out_valid), .out_k1(out_k1),
    .out_k2(out_k2), .dc_valid(dc_valid), .dc_x(dc_x)
);

// File: tb/sim_dctpp_top.sv
module sim_dctpp_top;
    localparam int N  = 7;
    localparam int G  = 3;
    localparam int W  = 8;
    localparam int M  = 8;
    localparam int KW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_tag = 1'b0;
    logic signed [W-1:0] in_xa0 = '0, in_y1 = '0, in_y2 = '0;
    logic out_valid, dc_valid;
    logic [KW-1:0] out_k1, out_k2;
    logic signed [W+1:0] out_x1, out_x2;
    logic signed [W-1:0] dc_x;

    int checks = 0;
    int fails = 0;

    typedef struct {
        bit    v;
        bit    dc;
        int    k1, k2, x1, x2, d;
        string rq;
    } exp_t;

    exp_t e1, e2;
    bit m_in = 0;
    int m_j = 0;
    int m_hold = 0;

    always #5 clk = ~clk;

    dctpp_top #(.N(N), .G(G), .W(W), .M(M)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
        .in_xa0(in_xa0), .in_y1(in_y1), .in_y2(in_y2),
        .out_valid(out_valid), .out_k1(out_k1), .out_x1(out_x1),
        .out_k2(out_k2), .out_x2(out_x2), .dc_valid(dc_valid), .dc_x(dc_x)
    );

    function automatic int pw(int j);
        int r = 1;
        for (int i = 0; i < j; i++) r = (r * G) % N;
        return r;
    endfunction

    function automatic int cf(int k);
        return $rtoi($floor($cos(3.14159265358979 * k / (2.0 * N)) * (2.0 ** (M - 1))));
    endfunction

    function automatic int fin(int off, int y, int k);
        return ((off + 2 * y) * cf(k)) >>> (M - 1);
    endfunction

    task automatic chk(bit ok, string rq, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, expv);
        end
    endtask

    task automatic compare();
        int a1, a2;
        a1 = int'(out_x1);
        a2 = int'(out_x2);
        chk(out_valid == e2.v, e2.rq, "out_valid", int'(out_valid), int'(e2.v));
        chk(dc_valid == e2.dc, e2.rq, "dc_valid", int'(dc_valid), int'(e2.dc));
        if (e2.v && out_valid) begin
            chk(int'(out_k1) == e2.k1, "R4", "out_k1", int'(out_k1), e2.k1);
            chk(int'(out_k2) == e2.k2, "R4", "out_k2", int'(out_k2), e2.k2);
            chk(a1 - e2.x1 <= 1 && e2.x1 - a1 <= 1, e2.rq, "out_x1", a1, e2.x1);
            chk(a2 - e2.x2 <= 1 && e2.x2 - a2 <= 1, e2.rq, "out_x2", a2, e2.x2);
        end
        if (e2.dc && dc_valid)
            chk(int'(dc_x) == e2.d, "R2", "dc_x", int'(dc_x), e2.d);
    endtask

    task automatic step(bit v, bit tag, int xa, int y1, int y2, string rq);
        exp_t n;
        bit acc;
        int j, off;
        @(negedge clk);
        compare();
        in_valid = v;
        in_tag   = tag;
        in_xa0   = W'(xa);
        in_y1    = W'(y1);
        in_y2    = W'(y2);
        n.v = 0; n.dc = 0; n.k1 = 0; n.k2 = 0; n.x1 = 0; n.x2 = 0; n.d = 0; n.rq = rq;
        acc = v && (tag || m_in);
        if (acc) begin
            j   = tag ? 0 : m_j;
            off = tag ? xa : m_hold;
            if (tag) m_hold = xa;
            n.v  = 1;
            n.dc = tag;
            n.d  = xa;
            n.k1 = pw(j);
            n.k2 = N - n.k1;
            n.x1 = fin(off, y1, n.k1);
            n.x2 = fin(off, y2, n.k2);
            if (j == (N - 1) / 2 - 1) begin m_in = 0; m_j = 0; end
            else begin m_in = 1; m_j = j + 1; end
        end
        e2 = e1;
        e1 = n;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        e1.v = 0; e1.dc = 0; e1.rq = "R1";
        e2 = e1;
        repeat (3) begin
            @(negedge clk);
            chk(!out_valid && !dc_valid, "R1", "valid in reset", int'(out_valid | dc_valid), 0);
        end
        rst_n = 1'b1;
        // R1 first cycles after reset
        step(0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 0, "R1");
        // R3 R4 R5: full sweep of y1/y2 against spread offsets, junk xa0 on untagged beats
        for (int xi = 0; xi < 16; xi++) begin
            for (int b = 0; b < 258; b++) begin
                int yv;
                yv = (b % 256) - 128;
                step(1, (b % 3) == 0, (b % 3) == 0 ? -128 + xi * 17 : 99 - b, yv, -1 - yv, "R3");
            end
        end
        // R6: untagged beats outside a frame
        step(1, 0, 5, 10, 20, "R6");
        step(1, 0, 5, 10, 20, "R6");
        step(0, 0, 0, 0, 0, "R6");
        // R7: restart in mid-frame
        step(1, 1, 40, 3, 4, "R7");
        step(1, 0, 0, 5, 6, "R7");
        step(1, 1, -77, 7, 8, "R7");
        step(1, 0, 0, 9, 10, "R7");
        step(1, 0, 0, -11, 12, "R7");
        // R8: gaps inside a frame
        step(1, 1, 127, 127, -128, "R8");
        step(0, 0, 3, 1, 1, "R8");
        step(1, 0, 0, 127, 127, "R8");
        step(0, 1, 3, 1, 1, "R8");
        step(0, 0, 3, 1, 1, "R8");
        step(1, 0, 0, -128, -128, "R8");
        step(1, 0, 0, 1, 1, "R6");
        // R2: back-to-back tagged beats, extreme DC words
        step(1, 1, -128, -128, -128, "R2");
        step(1, 1, 127, 127, 127, "R2");
        step(0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 0, "R9");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule